// File: doc/BRIEF.md
# Key-Locked GPIO Configuration Register Bank

This block is the software-facing register file of a 32-pin general-purpose I/O controller. It is word-addressed with 32-bit words. It holds the pin configuration: polarity, output data, output enable, open-drain type, pull-up, pull-down, input enable mask and pin muxing. It also holds the event configuration, four blink words, a debounce word, and the slew and drive-strength words. Every register value goes out on a dedicated output to the pin-resolution and event-detection logic next to it. The input level and the event status come back from that logic on inputs, so software can read them through the bus.

Two of the addresses form a write freeze. While the bank is unlocked, a write to either lock address freezes it. While the bank is frozen, every configuration write is refused and flagged. The only writes it accepts are a store into the second lock word and the key write to the first lock word. The bank unfreezes only when the first word receives the release key while the second word already holds the companion key.

Set and clear aliases let software change individual bits of the output data, output enable and event enable without a read-modify-write. A one-cycle strobe tells the pin logic that a pin-related register was written. A separate one-cycle pulse carries the clear mask that software writes to the event status address.

Top module: `gpio_keylock_bank`

## Requirements
- R1: After reset the bank is unlocked and every register reads 0, except pull-up, pull-down, slew and drive, which take the values of parameters RST_PU, RST_PD, RST_SLEW and RST_DRIVE.
- R2: While unlocked, a write of any value to byte offset 0x00 or to 0x7C locks the bank from the next cycle. A read of 0x00 then returns 1, and the word at 0x7C is cleared.
- R3: While locked, a write to any offset other than 0x00 and 0x7C changes no register and returns bus_err in the response cycle.
- R4: While locked, a write to 0x7C stores its value. A write of KEY_A (default 0xC0DEFA73) to 0x00 unlocks the bank only when 0x7C holds KEY_B (default 0xC0DE1248). Any other value, or any other content of 0x7C, leaves the bank locked.
- R5: Output data lives at 0x0C. A write to 0x68 ORs the written mask into it, and a write to 0x6C clears the masked bits.
- R6: Output enable lives at 0x10. A write to 0x70 sets the masked bits and a write to 0x74 clears them.
- R7: Event enable lives at 0x40. A write to 0x44 sets the masked bits and a write to 0x48 clears them.
- R8: A read of 0x04 returns pin_din. A write to 0x04 changes nothing and returns bus_err.
- R9: A read of 0x44, 0x48, 0x68, 0x6C, 0x70, 0x74 or 0x7C returns 0 with bus_err.
- R10: An access to an address whose low two bits are not zero, to a word offset of 0x80 or above, or to 0x50, 0x54, 0x64 or 0x78 reads 0 and writes nothing. It raises bus_err for exactly the response cycle.
- R11: cfg_update pulses for one cycle after an accepted write to 0x08, 0x0C, 0x10, 0x14, 0x1C, 0x20, 0x58 or 0x68 to 0x74, and stays low after any other write.
- R12: A read of 0x4C returns evt_status. An accepted write to 0x4C pulses evt_clr_valid for one cycle, with evt_clr_mask equal to the written value.
- R13: The plain storage words read back what was written: mux 0x18, debounce 0x24, event type 0x28, both-edge select 0x2C, blink 0x30 to 0x3C, slew 0x5C and drive 0x60.
- R14: Every response (bus_rdata, bus_rvalid, bus_err, cfg_update, evt_clr_valid) and every register change appears in the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_rvalid | output | 1 | Read response valid |
| bus_err | output | 1 | Access refused or invalid, one-cycle pulse |
| pin_din | input | 32 | Resolved input levels from the pin logic |
| evt_status | input | 32 | Event status from the event logic |
| cfg_pol | output | 32 | Polarity |
| cfg_dout | output | 32 | Output data |
| cfg_oe | output | 32 | Output enable |
| cfg_otyp | output | 32 | Open-drain select |
| cfg_pu | output | 32 | Pull-up enable |
| cfg_pd | output | 32 | Pull-down enable |
| cfg_iem | output | 32 | Input enable mask |
| cfg_mux | output | 32 | Pin mux word |
| cfg_dbnc | output | 32 | Debounce word |
| cfg_evtyp | output | 32 | Event type (edge/level) |
| cfg_evbe | output | 32 | Both-edge select |
| cfg_even | output | 32 | Event enable |
| cfg_slew | output | 32 | Slew word |
| cfg_drive | output | 32 | Drive-strength word |
| cfg_blink | output | 128 | Four blink words, word n in bits 32n+31:32n |
| locked | output | 1 | Bank is frozen |
| cfg_update | output | 1 | Pin-related register written, one-cycle pulse |
| evt_clr_valid | output | 1 | Event status clear request, one-cycle pulse |
| evt_clr_mask | output | 32 | Bits to clear in the event status |

## Verification
The lock engine and the configuration writer both judge the same bus write in the same cycle. The gate that a write meets must therefore be the lock state left by the write just before it. The bench issues a lock write and a configuration write on consecutive cycles with no gap, then a key store, the release key and a configuration write, again back to back. It then requires the first configuration write to be refused with bus_err and an unchanged output, and the last one to be accepted with cfg_update and the new value.

// File: rtl/gpio_keylock_pkg.sv
package gpio_keylock_pkg;

  localparam int unsigned DATA_W      = 32;
  localparam int unsigned IDX_W       = 5;
  localparam int unsigned NBLINK      = 4;
  localparam int unsigned BLINK_BASE  = 12;
  localparam int unsigned BLINK_SEL_W = $clog2(NBLINK);

  // Word index = byte offset / 4.
  typedef enum logic [IDX_W-1:0] {
    RG_LOCKA    = 5'd0,
    RG_DIN      = 5'd1,
    RG_POL      = 5'd2,
    RG_DOUT     = 5'd3,
    RG_OE       = 5'd4,
    RG_OTYP     = 5'd5,
    RG_MUX      = 5'd6,
    RG_PU       = 5'd7,
    RG_PD       = 5'd8,
    RG_DBNC     = 5'd9,
    RG_EVTYP    = 5'd10,
    RG_EVBE     = 5'd11,
    RG_BLK0     = 5'd12,
    RG_BLK1     = 5'd13,
    RG_BLK2     = 5'd14,
    RG_BLK3     = 5'd15,
    RG_EVEN     = 5'd16,
    RG_EVEN_SET = 5'd17,
    RG_EVEN_CLR = 5'd18,
    RG_EVST     = 5'd19,
    RG_IEM      = 5'd22,
    RG_SLEW     = 5'd23,
    RG_DRIVE    = 5'd24,
    RG_DOUT_SET = 5'd26,
    RG_DOUT_CLR = 5'd27,
    RG_OE_SET   = 5'd28,
    RG_OE_CLR   = 5'd29,
    RG_LOCKB    = 5'd31
  } reg_id_e;

  typedef enum logic [1:0] {
    RC_NONE,  // unmapped
    RC_RW,    // readable and writable
    RC_WO,    // write-only, reads give 0 with error
    RC_RO     // read-only, writes refused with error
  } reg_class_e;

  typedef struct packed {
    logic             aligned;
    logic             inrange;
    logic [IDX_W-1:0] idx;
    reg_class_e       cls;
  } acc_t;

  function automatic reg_class_e class_of(input logic [IDX_W-1:0] idx);
    case (idx)
      RG_DIN:                                   return RC_RO;
      RG_EVEN_SET, RG_EVEN_CLR, RG_DOUT_SET,
      RG_DOUT_CLR, RG_OE_SET, RG_OE_CLR,
      RG_LOCKB:                                 return RC_WO;
      5'd20, 5'd21, 5'd25, 5'd30:               return RC_NONE;
      default:                                  return RC_RW;
    endcase
  endfunction

  function automatic logic is_pin_reg(input logic [IDX_W-1:0] idx);
    case (idx)
      RG_POL, RG_DOUT, RG_OE, RG_OTYP, RG_PU, RG_PD, RG_IEM,
      RG_DOUT_SET, RG_DOUT_CLR, RG_OE_SET, RG_OE_CLR: return 1'b1;
      default:                                         return 1'b0;
    endcase
  endfunction

  // Set or clear the masked bits of a word.
  function automatic logic [DATA_W-1:0] merge_mask(input logic [DATA_W-1:0] old_w,
                                                   input logic [DATA_W-1:0] mask,
                                                   input logic              set);
    return set ? (old_w | mask) : (old_w & ~mask);
  endfunction

endpackage

// File: rtl/gpio_kl_decode.sv
module gpio_kl_decode
  import gpio_keylock_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output acc_t              acc
);
  localparam int unsigned LSB = 2;
  localparam int unsigned TOP = LSB + IDX_W;

  logic             al;
  logic             rng;
  logic [IDX_W-1:0] wi;

  always_comb begin
    al      = (addr[LSB-1:0] == '0);
    rng     = (addr[ADDR_W-1:TOP] == '0);
    wi      = addr[TOP-1:LSB];
    acc.aligned = al;
    acc.inrange = rng;
    acc.idx     = wi;
    acc.cls     = (al && rng) ? class_of(wi) : RC_NONE;
  end
endmodule

// File: rtl/gpio_kl_lock.sv
module gpio_kl_lock
  import gpio_keylock_pkg::*;
#(
  parameter logic [DATA_W-1:0] KEY_A = 32'hC0DE_FA73,
  parameter logic [DATA_W-1:0] KEY_B = 32'hC0DE_1248
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic              locked,
  output logic              lock_set,
  output logic              lock_clear
);
  logic              frozen;
  logic [DATA_W-1:0] key_word;
  logic              hit_a, hit_b, b_load;

  assign hit_a      = (idx == RG_LOCKA);
  assign hit_b      = (idx == RG_LOCKB);
  assign locked     = frozen;
  assign lock_set   = wr_stb && !frozen && (hit_a || hit_b);
  assign lock_clear = wr_stb && frozen && hit_a && (key_word == KEY_B) && (wdata == KEY_A);
  assign b_load     = wr_stb && frozen && hit_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frozen   <= 1'b0;
      key_word <= '0;
    end else if (lock_set) begin
      frozen   <= 1'b1;
      key_word <= '0;
    end else if (lock_clear) begin
      frozen   <= 1'b0;
      key_word <= '0;
    end else if (b_load) begin
      key_word <= wdata;
    end
  end
endmodule

// File: rtl/gpio_kl_regs.sv
module gpio_kl_regs
  import gpio_keylock_pkg::*;
#(
  parameter logic [DATA_W-1:0] RST_PU    = '0,
  parameter logic [DATA_W-1:0] RST_PD    = '0,
  parameter logic [DATA_W-1:0] RST_SLEW  = '0,
  parameter logic [DATA_W-1:0] RST_DRIVE = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         idx,
  input  logic [DATA_W-1:0]        wdata,
  output logic [DATA_W-1:0]        pol,
  output logic [DATA_W-1:0]        dout,
  output logic [DATA_W-1:0]        oe,
  output logic [DATA_W-1:0]        otyp,
  output logic [DATA_W-1:0]        mux,
  output logic [DATA_W-1:0]        pu,
  output logic [DATA_W-1:0]        pd,
  output logic [DATA_W-1:0]        dbnc,
  output logic [DATA_W-1:0]        evtyp,
  output logic [DATA_W-1:0]        evbe,
  output logic [DATA_W-1:0]        even,
  output logic [DATA_W-1:0]        iem,
  output logic [DATA_W-1:0]        slew,
  output logic [DATA_W-1:0]        drive,
  output logic [NBLINK*DATA_W-1:0] blink
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pol   <= '0;
      dout  <= '0;
      oe    <= '0;
      otyp  <= '0;
      mux   <= '0;
      pu    <= RST_PU;
      pd    <= RST_PD;
      dbnc  <= '0;
      evtyp <= '0;
      evbe  <= '0;
      even  <= '0;
      iem   <= '0;
      slew  <= RST_SLEW;
      drive <= RST_DRIVE;
    end else if (wr_en) begin
      case (idx)
        RG_POL:      pol   <= wdata;
        RG_DOUT:     dout  <= wdata;
        RG_OE:       oe    <= wdata;
        RG_OTYP:     otyp  <= wdata;
        RG_MUX:      mux   <= wdata;
        RG_PU:       pu    <= wdata;
        RG_PD:       pd    <= wdata;
        RG_DBNC:     dbnc  <= wdata;
        RG_EVTYP:    evtyp <= wdata;
        RG_EVBE:     evbe  <= wdata;
        RG_EVEN:     even  <= wdata;
        RG_IEM:      iem   <= wdata;
        RG_SLEW:     slew  <= wdata;
        RG_DRIVE:    drive <= wdata;
        RG_DOUT_SET: dout  <= merge_mask(dout, wdata, 1'b1);
        RG_DOUT_CLR: dout  <= merge_mask(dout, wdata, 1'b0);
        RG_OE_SET:   oe    <= merge_mask(oe, wdata, 1'b1);
        RG_OE_CLR:   oe    <= merge_mask(oe, wdata, 1'b0);
        RG_EVEN_SET: even  <= merge_mask(even, wdata, 1'b1);
        RG_EVEN_CLR: even  <= merge_mask(even, wdata, 1'b0);
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NBLINK; g++) begin : g_blink
    logic [DATA_W-1:0] word;
    always_ff @(posedge clk) begin
      if (!rst_n)
        word <= '0;
      else if (wr_en && (idx == IDX_W'(BLINK_BASE + g)))
        word <= wdata;
    end
    assign blink[g*DATA_W +: DATA_W] = word;
  end
endmodule

// File: rtl/gpio_keylock_bank.sv
module gpio_keylock_bank
  import gpio_keylock_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 12,
  parameter logic [DATA_W-1:0] RST_PU    = '0,
  parameter logic [DATA_W-1:0] RST_PD    = '0,
  parameter logic [DATA_W-1:0] RST_SLEW  = '0,
  parameter logic [DATA_W-1:0] RST_DRIVE = '0,
  parameter logic [DATA_W-1:0] KEY_A     = 32'hC0DE_FA73,
  parameter logic [DATA_W-1:0] KEY_B     = 32'hC0DE_1248
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_req,
  input  logic                     bus_wr,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [DATA_W-1:0]        bus_rdata,
  output logic                     bus_rvalid,
  output logic                     bus_err,
  input  logic [DATA_W-1:0]        pin_din,
  input  logic [DATA_W-1:0]        evt_status,
  output logic [DATA_W-1:0]        cfg_pol,
  output logic [DATA_W-1:0]        cfg_dout,
  output logic [DATA_W-1:0]        cfg_oe,
  output logic [DATA_W-1:0]        cfg_otyp,
  output logic [DATA_W-1:0]        cfg_pu,
  output logic [DATA_W-1:0]        cfg_pd,
  output logic [DATA_W-1:0]        cfg_iem,
  output logic [DATA_W-1:0]        cfg_mux,
  output logic [DATA_W-1:0]        cfg_dbnc,
  output logic [DATA_W-1:0]        cfg_evtyp,
  output logic [DATA_W-1:0]        cfg_evbe,
  output logic [DATA_W-1:0]        cfg_even,
  output logic [DATA_W-1:0]        cfg_slew,
  output logic [DATA_W-1:0]        cfg_drive,
  output logic [NBLINK*DATA_W-1:0] cfg_blink,
  output logic                     locked,
  output logic                     cfg_update,
  output logic                     evt_clr_valid,
  output logic [DATA_W-1:0]        evt_clr_mask
);

  acc_t              acc;
  logic              mapped, lock_target;
  logic              wr_fire, rd_fire;
  logic              lock_stb, cfg_accept;
  logic              wr_reject, rd_reject;
  logic              lock_set, lock_clear;
  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] blink_w [NBLINK];

  gpio_kl_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .acc  (acc)
  );

  // Named access events, also observed by the bound checker.
  assign mapped      = (acc.cls != RC_NONE);
  assign lock_target = (acc.idx == RG_LOCKA) || (acc.idx == RG_LOCKB);
  assign wr_fire     = bus_req && bus_wr;
  assign rd_fire     = bus_req && !bus_wr;
  assign lock_stb    = wr_fire && mapped && lock_target;
  assign cfg_accept  = wr_fire && mapped && !locked && !lock_target && (acc.cls != RC_RO);
  assign wr_reject   = wr_fire && (!mapped || (acc.cls == RC_RO) || (locked && !lock_target));
  assign rd_reject   = rd_fire && (!mapped || (acc.cls == RC_WO));

  gpio_kl_lock #(.KEY_A(KEY_A), .KEY_B(KEY_B)) u_lock (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_stb     (lock_stb),
    .idx        (acc.idx),
    .wdata      (bus_wdata),
    .locked     (locked),
    .lock_set   (lock_set),
    .lock_clear (lock_clear)
  );

  gpio_kl_regs #(
    .RST_PU    (RST_PU),
    .RST_PD    (RST_PD),
    .RST_SLEW  (RST_SLEW),
    .RST_DRIVE (RST_DRIVE)
  ) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (cfg_accept),
    .idx   (acc.idx),
    .wdata (bus_wdata),
    .pol   (cfg_pol),
    .dout  (cfg_dout),
    .oe    (cfg_oe),
    .otyp  (cfg_otyp),
    .mux   (cfg_mux),
    .pu    (cfg_pu),
    .pd    (cfg_pd),
    .dbnc  (cfg_dbnc),
    .evtyp (cfg_evtyp),
    .evbe  (cfg_evbe),
    .even  (cfg_even),
    .iem   (cfg_iem),
    .slew  (cfg_slew),
    .drive (cfg_drive),
    .blink (cfg_blink)
  );

  for (genvar g = 0; g < NBLINK; g++) begin : g_bw
    assign blink_w[g] = cfg_blink[g*DATA_W +: DATA_W];
  end

  always_comb begin
    case (acc.idx)
      RG_LOCKA: rd_word = {{(DATA_W-1){1'b0}}, locked};
      RG_DIN:   rd_word = pin_din;
      RG_POL:   rd_word = cfg_pol;
      RG_DOUT:  rd_word = cfg_dout;
      RG_OE:    rd_word = cfg_oe;
      RG_OTYP:  rd_word = cfg_otyp;
      RG_MUX:   rd_word = cfg_mux;
      RG_PU:    rd_word = cfg_pu;
      RG_PD:    rd_word = cfg_pd;
      RG_DBNC:  rd_word = cfg_dbnc;
      RG_EVTYP: rd_word = cfg_evtyp;
      RG_EVBE:  rd_word = cfg_evbe;
      RG_BLK0, RG_BLK1, RG_BLK2, RG_BLK3:
                rd_word = blink_w[acc.idx[BLINK_SEL_W-1:0]];
      RG_EVEN:  rd_word = cfg_even;
      RG_EVST:  rd_word = evt_status;
      RG_IEM:   rd_word = cfg_iem;
      RG_SLEW:  rd_word = cfg_slew;
      RG_DRIVE: rd_word = cfg_drive;
      default:  rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata     <= '0;
      bus_rvalid    <= 1'b0;
      bus_err       <= 1'b0;
      cfg_update    <= 1'b0;
      evt_clr_valid <= 1'b0;
      evt_clr_mask  <= '0;
    end else begin
      bus_rvalid    <= rd_fire;
      bus_rdata     <= (rd_fire && !rd_reject) ? rd_word : '0;
      bus_err       <= wr_reject || rd_reject;
      cfg_update    <= cfg_accept && is_pin_reg(acc.idx);
      evt_clr_valid <= cfg_accept && (acc.idx == RG_EVST);
      evt_clr_mask  <= (cfg_accept && (acc.idx == RG_EVST)) ? bus_wdata : '0;
    end
  end
endmodule

// File: rtl/gpio_keylock_bank_chk.sv
module gpio_keylock_bank_chk
  import gpio_keylock_pkg::*;
#(
  parameter int unsigned       ADDR_W = 12,
  parameter logic [DATA_W-1:0] KEY_A  = 32'hC0DE_FA73
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_err,
  input logic [DATA_W-1:0] cfg_dout,
  input logic [DATA_W-1:0] cfg_oe,
  input logic [DATA_W-1:0] cfg_even,
  input logic              locked,
  input logic              cfg_update,
  input logic              lock_set,
  input logic              lock_clear,
  input logic              cfg_accept
);
  logic wr_op, rd_op, at_lock;
  assign wr_op   = bus_req && bus_wr;
  assign rd_op   = bus_req && !bus_wr;
  assign at_lock = (bus_addr == ADDR_W'(8'h00)) || (bus_addr == ADDR_W'(8'h7C));

  p_engage_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lock_set |=> locked);

  p_locked_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && wr_op && !at_lock) |=> (bus_err && $stable(cfg_dout) && $stable(cfg_oe) && $stable(cfg_even)));

  p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lock_clear |=> !locked);

  p_wrong_key_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && wr_op && (bus_addr == ADDR_W'(8'h00)) && (bus_wdata != KEY_A)) |=> locked);

  p_dout_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && wr_op && (bus_addr == ADDR_W'(8'h68))) |=> (cfg_dout == ($past(cfg_dout) | $past(bus_wdata))));

  p_oe_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && wr_op && (bus_addr == ADDR_W'(8'h74))) |=> (cfg_oe == ($past(cfg_oe) & ~$past(bus_wdata))));

  p_wo_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_op && (bus_addr == ADDR_W'(8'h7C))) |=> (bus_err && (bus_rdata == '0)));

  p_err_origin_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(bus_req));

  p_update_origin_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_update |-> $past(cfg_accept));
endmodule

bind gpio_keylock_bank gpio_keylock_bank_chk #(.ADDR_W(ADDR_W), .KEY_A(KEY_A)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_req    (bus_req),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .bus_err    (bus_err),
  .cfg_dout   (cfg_dout),
  .cfg_oe     (cfg_oe),
  .cfg_even   (cfg_even),
  .locked     (locked),
  .cfg_update (cfg_update),
  .lock_set   (lock_set),
  .lock_clear (lock_clear),
  .cfg_accept (cfg_accept)
);

// File: tb/test_gpio_keylock_bank.sv
`timescale 1ns/1ps
module test_gpio_keylock_bank;
  localparam int unsigned AW = 12;
  localparam logic [31:0] PU_R    = 32'h0000_00F0;
  localparam logic [31:0] PD_R    = 32'h0F00_0000;
  localparam logic [31:0] SLEW_R  = 32'h1234_0000;
  localparam logic [31:0] DRIVE_R = 32'h0000_5678;
  localparam logic [31:0] KA      = 32'hC0DE_FA73;
  localparam logic [31:0] KB      = 32'hC0DE_1248;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_req = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          bus_rvalid, bus_err;
  logic [31:0]   pin_din = '0, evt_status = '0;
  logic [31:0]   cfg_pol, cfg_dout, cfg_oe, cfg_otyp, cfg_pu, cfg_pd, cfg_iem;
  logic [31:0]   cfg_mux, cfg_dbnc, cfg_evtyp, cfg_evbe, cfg_even, cfg_slew, cfg_drive;
  logic [127:0]  cfg_blink;
  logic          locked, cfg_update, evt_clr_valid;
  logic [31:0]   evt_clr_mask;

  int n_cmp = 0;
  int n_bad = 0;

  // Response captured by the access tasks.
  logic [31:0] r_data;
  logic        r_err, r_upd, r_clr;
  logic [31:0] r_mask;

  always #2.5 clk = ~clk;

  gpio_keylock_bank #(
    .ADDR_W(AW), .RST_PU(PU_R), .RST_PD(PD_R), .RST_SLEW(SLEW_R), .RST_DRIVE(DRIVE_R),
    .KEY_A(KA), .KEY_B(KB)
  ) i_gpio_keylock_bank (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .bus_err(bus_err),
    .pin_din(pin_din), .evt_status(evt_status), .cfg_pol(cfg_pol), .cfg_dout(cfg_dout),
    .cfg_oe(cfg_oe), .cfg_otyp(cfg_otyp), .cfg_pu(cfg_pu), .cfg_pd(cfg_pd), .cfg_iem(cfg_iem),
    .cfg_mux(cfg_mux), .cfg_dbnc(cfg_dbnc), .cfg_evtyp(cfg_evtyp), .cfg_evbe(cfg_evbe),
    .cfg_even(cfg_even), .cfg_slew(cfg_slew), .cfg_drive(cfg_drive), .cfg_blink(cfg_blink),
    .locked(locked), .cfg_update(cfg_update), .evt_clr_valid(evt_clr_valid),
    .evt_clr_mask(evt_clr_mask)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic capture();
    r_data = bus_rdata; r_err = bus_err; r_upd = cfg_update;
    r_clr = evt_clr_valid; r_mask = evt_clr_mask;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_wr = 1'b0;
    capture();
  endtask

  task automatic rd(input logic [AW-1:0] a);
    @(negedge clk);
    bus_req = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
    capture();
    chk("R14 rvalid", {31'd0, bus_rvalid}, 32'd1);
  endtask

  task automatic t_reset();
    chk("R1 locked", {31'd0, locked}, 32'd0);
    chk("R1 pu", cfg_pu, PU_R);
    chk("R1 pd", cfg_pd, PD_R);
    chk("R1 slew", cfg_slew, SLEW_R);
    chk("R1 drive", cfg_drive, DRIVE_R);
    chk("R1 dout", cfg_dout, 32'd0);
    chk("R1 oe", cfg_oe, 32'd0);
    chk("R1 blink", cfg_blink[31:0], 32'd0);
    rd(12'h000); chk("R1 lock read", r_data, 32'd0);
    rd(12'h014); chk("R1 otyp read", r_data, 32'd0);
  endtask

  task automatic t_storage();
    wr(12'h018, 32'hDEAD_0001); chk("R11 no strobe on mux", {31'd0, r_upd}, 32'd0);
    rd(12'h018); chk("R13 mux", r_data, 32'hDEAD_0001);
    wr(12'h038, 32'h0000_5A5A);
    rd(12'h038); chk("R13 blink2", r_data, 32'h0000_5A5A);
    chk("R13 blink2 port", cfg_blink[95:64], 32'h0000_5A5A);
    wr(12'h05C, 32'hFFFF_0000);
    rd(12'h05C); chk("R13 slew", r_data, 32'hFFFF_0000);
    wr(12'h02C, 32'h0000_0081);
    rd(12'h02C); chk("R13 evbe", r_data, 32'h0000_0081);
  endtask

  task automatic t_dout();
    wr(12'h00C, 32'h0000_FF00);
    chk("R11 strobe dout", {31'd0, r_upd}, 32'd1);
    chk("R14 dout", cfg_dout, 32'h0000_FF00);
    wr(12'h068, 32'h0000_00F0);
    chk("R5 set", cfg_dout, 32'h0000_FFF0);
    chk("R11 strobe set", {31'd0, r_upd}, 32'd1);
    wr(12'h06C, 32'h0000_F000);
    chk("R5 clr", cfg_dout, 32'h0000_0FF0);
    rd(12'h00C); chk("R5 readback", r_data, 32'h0000_0FF0);
    chk("R11 strobe one cycle", {31'd0, cfg_update}, 32'd0);
  endtask

  task automatic t_oe();
    wr(12'h070, 32'h3); wr(12'h070, 32'hC);
    chk("R6 set", cfg_oe, 32'hF);
    wr(12'h074, 32'h5);
    chk("R6 clr", cfg_oe, 32'hA);
    rd(12'h010); chk("R6 readback", r_data, 32'hA);
  endtask

  task automatic t_even();
    wr(12'h040, 32'h11);
    chk("R11 no strobe on even", {31'd0, r_upd}, 32'd0);
    wr(12'h044, 32'h100);
    chk("R7 set", cfg_even, 32'h111);
    wr(12'h048, 32'h10);
    chk("R7 clr", cfg_even, 32'h101);
  endtask

  task automatic t_din();
    pin_din = 32'hA5A5_0F0F;
    rd(12'h004); chk("R8 read", r_data, 32'hA5A5_0F0F);
    wr(12'h004, 32'h0);
    chk("R8 write err", {31'd0, r_err}, 32'd1);
    rd(12'h004); chk("R8 unchanged", r_data, 32'hA5A5_0F0F);
  endtask

  task automatic t_wo();
    logic [AW-1:0] lst [7] = '{12'h044, 12'h048, 12'h068, 12'h06C, 12'h070, 12'h074, 12'h07C};
    for (int i = 0; i < 7; i++) begin
      rd(lst[i]);
      chk("R9 data", r_data, 32'd0);
      chk("R9 err", {31'd0, r_err}, 32'd1);
    end
  endtask

  task automatic t_unmapped();
    rd(12'h050); chk("R10 read data", r_data, 32'd0); chk("R10 read err", {31'd0, r_err}, 32'd1);
    @(negedge clk); chk("R10 err one cycle", {31'd0, bus_err}, 32'd0);
    wr(12'h064, 32'hFFFF_FFFF); chk("R10 hole err", {31'd0, r_err}, 32'd1);
    wr(12'h200, 32'hFFFF_FFFF); chk("R10 range err", {31'd0, r_err}, 32'd1);
    wr(12'h00E, 32'hFFFF_FFFF); chk("R10 misaligned err", {31'd0, r_err}, 32'd1);
    chk("R10 dout unchanged", cfg_dout, 32'h0000_0FF0);
    chk("R11 no strobe misaligned", {31'd0, r_upd}, 32'd0);
  endtask

  task automatic t_evst();
    evt_status = 32'h0000_00C3;
    rd(12'h04C); chk("R12 status read", r_data, 32'h0000_00C3);
    wr(12'h04C, 32'h0000_0041);
    chk("R12 clr valid", {31'd0, r_clr}, 32'd1);
    chk("R12 clr mask", r_mask, 32'h0000_0041);
    @(negedge clk); chk("R12 clr one cycle", {31'd0, evt_clr_valid}, 32'd0);
  endtask

  task automatic t_lock();
    wr(12'h07C, 32'h0000_1234);
    chk("R2 lock via 7C", {31'd0, locked}, 32'd1);
    rd(12'h000); chk("R2 lock reads 1", r_data, 32'd1);
    wr(12'h00C, 32'hFFFF_FFFF);
    chk("R3 err", {31'd0, r_err}, 32'd1);
    chk("R3 dout held", cfg_dout, 32'h0000_0FF0);
    chk("R11 no strobe locked", {31'd0, r_upd}, 32'd0);
    wr(12'h070, 32'hFFFF_FFFF);
    chk("R3 alias held", cfg_oe, 32'hA);
    wr(12'h000, KA);
    chk("R4 key without companion", {31'd0, locked}, 32'd1);
    wr(12'h07C, KB);
    chk("R4 store no err", {31'd0, r_err}, 32'd0);
    wr(12'h000, KA ^ 32'h1);
    chk("R4 wrong key", {31'd0, locked}, 32'd1);
    wr(12'h000, KA);
    chk("R4 release", {31'd0, locked}, 32'd0);
    rd(12'h000); chk("R4 lock reads 0", r_data, 32'd0);
    wr(12'h000, 32'h0);
    chk("R2 lock via 00", {31'd0, locked}, 32'd1);
    wr(12'h07C, KB); wr(12'h000, KA);
    chk("R4 release again", {31'd0, locked}, 32'd0);
  endtask

  // Lock write, config write, key store, release, config write: no gaps.
  task automatic t_b2b();
    @(negedge clk);
    bus_req = 1'b1; bus_wr = 1'b1; bus_addr = 12'h000; bus_wdata = 32'h0;
    @(negedge clk);
    chk("R2 b2b locked", {31'd0, locked}, 32'd1);
    bus_addr = 12'h00C; bus_wdata = 32'h0000_AAAA;
    @(negedge clk);
    chk("R3 b2b err", {31'd0, bus_err}, 32'd1);
    chk("R3 b2b held", cfg_dout, 32'h0000_0FF0);
    bus_addr = 12'h07C; bus_wdata = KB;
    @(negedge clk);
    chk("R4 b2b store", {31'd0, bus_err}, 32'd0);
    bus_addr = 12'h000; bus_wdata = KA;
    @(negedge clk);
    chk("R4 b2b release", {31'd0, locked}, 32'd0);
    bus_addr = 12'h00C; bus_wdata = 32'h0000_AAAA;
    @(negedge clk);
    bus_req = 1'b0; bus_wr = 1'b0;
    chk("R14 b2b accept", cfg_dout, 32'h0000_AAAA);
    chk("R11 b2b strobe", {31'd0, cfg_update}, 32'd1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_storage();
    t_dout();
    t_oe();
    t_even();
    t_din();
    t_wo();
    t_unmapped();
    t_evst();
    t_lock();
    t_b2b();
    repeat (2) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule